// File: doc/BRIEF.md
# Edge-Selectable Capture Unit

This block watches two external capture pins and records the running 32-bit timer count whenever a pin makes a transition the software has chosen. Each channel can be set to react to rising transitions, falling transitions, both, or neither. When a channel's capture register is loaded it can also raise a pending flag. The flags combine into one interrupt request line.

A small register port gives access to the block. Software can write and read the control word and read the two capture registers. It reads the pending flags and clears them by writing ones. The pins are asynchronous to the block clock, so each one passes through a two-stage synchroniser before its transitions are detected. The block does not produce the timer count. The timer that owns the count drives it in.

Top module: `edge_capture_unit`

## Requirements
- R1: After a synchronous reset both capture values are 0, no flag is pending, `irq` is 0 and the control word reads back 0.
- R2: With its rising enable set, a 0-to-1 change on a channel's pin, applied between clock edges, loads the timer count present at the third following rising clock edge into that channel's capture register. The register is unchanged after the second edge. Register address 2 reads channel 0's value and address 3 reads channel 1's value.
- R3: With its falling enable set, a 1-to-0 change on a channel's pin loads the timer count with the same three-edge latency.
- R4: A transition whose polarity is not enabled for the channel leaves its capture register and flag unchanged.
- R5: With both enables set, every transition of either polarity loads the capture register.
- R6: A channel's flag becomes set only when a capture load happens on that channel while its interrupt enable is set. A load with the enable clear leaves the flag at 0.
- R7: Writing to address 0 clears the channel-c flag when data bit 4+c is 1 and leaves it alone when that bit is 0. Reading address 0 returns the flags in bits 5:4 and zeros elsewhere.
- R8: If a channel's flag is being set by a capture and cleared by a write in the same cycle, it ends up set.
- R9: `irq` is 1 exactly when at least one flag is set.
- R10: Writes to addresses 2 and 3 have no effect on the capture values.
- R11: The control word at address 1 holds 3 bits per channel: bit 3c is the rising enable, bit 3c+1 the falling enable, and bit 3c+2 the interrupt enable. It reads back what was written in bits 5:0, and bits above 5 read as 0.
- R12: The two channels are independent: activity on one pin never alters the other channel's capture value or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_count | input | 32 | Running timer value to be captured |
| cap_pin | input | 2 | Asynchronous capture pins, bit c for channel c |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select: 0 flags, 1 control, 2 and 3 captures |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| capture_vals | output | 64 | Capture values, channel c in bits 32c+31:32c |
| irq | output | 1 | OR of the pending flags |

## Verification
Two events can fall in the same cycle: a capture load that sets a channel's flag, and a software write that clears flags. The bench produces this by placing a clearing write exactly on the third clock edge after a pin transition. That write clears an older flag on the other channel, while the channel being loaded must keep its new flag. The result is judged by reading the flag register and `irq` on the next half cycle. The flag being loaded must survive and the other flag must be gone.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int NUM_CH_DEF   = 2;
    localparam int TIMER_W_DEF  = 32;
    localparam int CH_CTRL_W    = 3;
    localparam int FLAG_LSB     = 4;
    localparam int SYNC_DEPTH   = 2;

    localparam int ADDR_FLAGS   = 0;
    localparam int ADDR_CTRL    = 1;
    localparam int ADDR_CAPBASE = 2;

    // per-channel control bits, LSB first: rise, fall, irq enable
    typedef struct packed {
        logic irq_en;
        logic fall_en;
        logic rise_en;
    } ch_ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_BOTH = 2'b11
    } pol_sel_e;

    function automatic pol_sel_e pol_of(input ch_ctrl_t c);
        return pol_sel_e'({c.fall_en, c.rise_en});
    endfunction

    function automatic logic edge_hit(input ch_ctrl_t c, input edge_ev_t ev);
        logic hit;
        case (pol_of(c))
            POL_RISE: hit = ev.rise;
            POL_FALL: hit = ev.fall;
            POL_BOTH: hit = ev.rise | ev.fall;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge
    import cap_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output edge_ev_t ev
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    always_comb begin
        ev.rise =  sync_q[STAGES-1] & ~last_q;
        ev.fall = ~sync_q[STAGES-1] &  last_q;
    end

endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int TW = TIMER_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  ch_ctrl_t      ctrl,
    input  edge_ev_t      ev,
    input  logic [TW-1:0] timer,
    input  logic          flag_clr,
    output logic [TW-1:0] cap_q,
    output logic          flag_q,
    output logic          load
);

    assign load = edge_hit(ctrl, ev);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (load) cap_q <= timer;
            // a new capture outranks a clear landing in the same cycle
            if (load && ctrl.irq_en) flag_q <= 1'b1;
            else if (flag_clr)       flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import cap_pkg::*;
#(
    parameter  int NCH = NUM_CH_DEF,
    parameter  int TW  = TIMER_W_DEF,
    localparam int AW  = $clog2(NCH + ADDR_CAPBASE),
    localparam int CW  = NCH * CH_CTRL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TW-1:0]   timer_count,
    input  logic [NCH-1:0]  cap_pin,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [TW-1:0]   reg_wdata,
    output logic [TW-1:0]   reg_rdata,
    output logic [NCH*TW-1:0] capture_vals,
    output logic            irq
);

    logic [CW-1:0]  ctrl_q;
    logic [NCH-1:0] cap_load;
    logic [NCH-1:0] flag_q;
    logic [NCH-1:0] flag_clr;
    logic [NCH-1:0] irq_en_vec;
    logic [TW-1:0]  cap_q [NCH];

    wire sel_flags = (int'(reg_addr) == ADDR_FLAGS);
    wire sel_ctrl  = (int'(reg_addr) == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst)                  ctrl_q <= '0;
        else if (reg_wr && sel_ctrl) ctrl_q <= reg_wdata[CW-1:0];
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            ch_ctrl_t ch_ctrl;
            edge_ev_t ch_ev;

            assign ch_ctrl       = ch_ctrl_t'(ctrl_q[c*CH_CTRL_W +: CH_CTRL_W]);
            assign irq_en_vec[c] = ch_ctrl.irq_en;
            assign flag_clr[c]   = reg_wr & sel_flags & reg_wdata[FLAG_LSB + c];

            cap_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync (
                .clk (clk),
                .rst (rst),
                .pin (cap_pin[c]),
                .ev  (ch_ev)
            );

            cap_channel #(.TW(TW)) u_chan (
                .clk      (clk),
                .rst      (rst),
                .ctrl     (ch_ctrl),
                .ev       (ch_ev),
                .timer    (timer_count),
                .flag_clr (flag_clr[c]),
                .cap_q    (cap_q[c]),
                .flag_q   (flag_q[c]),
                .load     (cap_load[c])
            );

            assign capture_vals[c*TW +: TW] = cap_q[c];
        end
    endgenerate

    assign irq = |flag_q;

    always_comb begin
        reg_rdata = '0;
        if (sel_flags) begin
            reg_rdata[FLAG_LSB +: NCH] = flag_q;
        end else if (sel_ctrl) begin
            reg_rdata[CW-1:0] = ctrl_q;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (int'(reg_addr) == ADDR_CAPBASE + c) reg_rdata = cap_q[c];
            end
        end
    end

endmodule

// File: rtl/edge_capture_unit_chk.sv
module edge_capture_unit_chk #(
    parameter int NCH = 2,
    parameter int TW  = 32,
    parameter int AW  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [AW-1:0]     reg_addr,
    input logic [NCH*TW-1:0] capture_vals,
    input logic              irq,
    input logic [NCH-1:0]    cap_load,
    input logic [NCH-1:0]    flag_q,
    input logic [NCH-1:0]    irq_en_vec
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (irq == 1'b0 && capture_vals == '0));

    // R10
    capture_readonly_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && int'(reg_addr) >= 2 && cap_load == '0) |=> $stable(capture_vals));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            // R2
            cap_change_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
                (capture_vals[c*TW +: TW] != $past(capture_vals[c*TW +: TW])) |-> $past(cap_load[c]));

            // R6
            flag_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(flag_q[c]) |-> $past(cap_load[c] && irq_en_vec[c]));

            // R8
            set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (cap_load[c] && irq_en_vec[c]) |=> flag_q[c]);
        end
    endgenerate

endmodule

bind edge_capture_unit edge_capture_unit_chk #(.NCH(NCH), .TW(TW), .AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .capture_vals (capture_vals),
    .irq          (irq),
    .cap_load     (cap_load),
    .flag_q       (flag_q),
    .irq_en_vec   (irq_en_vec)
);

// File: tb/tb_edge_capture_unit.sv
module tb_edge_capture_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] timer_count = '0;
    logic [1:0]  cap_pin = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] capture_vals;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_cap [2];
    logic [1:0]  exp_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_capture_unit dut (
        .clk          (clk),
        .rst          (rst),
        .timer_count  (timer_count),
        .cap_pin      (cap_pin),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .capture_vals (capture_vals),
        .irq          (irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_state(input string tag);
        logic [31:0] v;
        check({tag, " cap0"}, capture_vals[31:0],  exp_cap[0]);
        check({tag, " cap1"}, capture_vals[63:32], exp_cap[1]);
        check({tag, " irq R9"}, irq, |exp_flag);
        rd(2'd0, v);
        check({tag, " flags R7"}, v, {26'd0, exp_flag, 4'd0});
    endtask

    // drive a pin level, then step the timer so that only the value at the
    // third clock edge can be captured; optionally clear flags on that edge
    task automatic pin_event(input int ch, input logic lvl, input logic [31:0] tval,
                             input logic do_load, input logic irq_en,
                             input logic [1:0] clr, input string tag);
        @(negedge clk);
        cap_pin[ch] = lvl;
        timer_count = tval - 32'd2;
        @(negedge clk);
        timer_count = tval - 32'd1;
        @(negedge clk);
        check({tag, " no load before third edge R2"}, capture_vals[ch*32 +: 32], exp_cap[ch]);
        timer_count = tval;
        if (clr != 2'b00) begin
            reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = {26'd0, clr, 4'd0};
        end
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        timer_count = tval + 32'd7;
        exp_flag = exp_flag & ~clr;
        if (do_load) begin
            exp_cap[ch] = tval;
            if (irq_en) exp_flag[ch] = 1'b1;
        end
        check_state(tag);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        exp_cap[0] = '0; exp_cap[1] = '0; exp_flag = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_state("R1 reset");
        rd(2'd1, v);
        check("R1 ctrl reset", v, 0);
    endtask

    task automatic t_ctrl_readback;
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v);
        check("R11 ctrl width", v, 32'h3F);
        // ch0: rise + irq (bits 0,2); ch1: fall only (bit 4)
        wr(2'd1, 32'h15);
        rd(2'd1, v);
        check("R11 ctrl value", v, 32'h15);
    endtask

    task automatic t_rise_capture;
        pin_event(0, 1'b1, 32'h100, 1'b1, 1'b1, 2'b00, "R2 R12 rise ch0");
    endtask

    task automatic t_disabled_polarity;
        pin_event(1, 1'b1, 32'h150, 1'b0, 1'b0, 2'b00, "R4 rise ch1 disabled");
        pin_event(1, 1'b0, 32'h200, 1'b1, 1'b0, 2'b00, "R3 R6 fall ch1 no irq");
        pin_event(0, 1'b0, 32'h250, 1'b0, 1'b1, 2'b00, "R4 fall ch0 disabled");
    endtask

    task automatic t_w1c;
        wr(2'd0, 32'h0000_0000);
        check_state("R7 write zero keeps");
        wr(2'd0, 32'h0000_0010);
        exp_flag[0] = 1'b0;
        check_state("R7 clear ch0");
    endtask

    task automatic t_both_edges;
        // ch0 rise+fall+irq (0x07), ch1 fall+irq (0x30)
        wr(2'd1, 32'h37);
        pin_event(0, 1'b1, 32'h300, 1'b1, 1'b1, 2'b00, "R5 both rise");
        pin_event(0, 1'b0, 32'h301, 1'b1, 1'b1, 2'b00, "R5 both fall");
    endtask

    task automatic t_set_wins;
        pin_event(1, 1'b1, 32'h380, 1'b0, 1'b1, 2'b00, "R4 ch1 rise off");
        pin_event(1, 1'b0, 32'h400, 1'b1, 1'b1, 2'b11, "R8 set beats clear");
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        wr(2'd2, 32'hDEAD_BEEF);
        wr(2'd3, 32'hCAFE_F00D);
        check_state("R10 readonly");
        rd(2'd2, v);
        check("R10 R2 read cap0", v, exp_cap[0]);
        rd(2'd3, v);
        check("R10 R3 read cap1", v, exp_cap[1]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ctrl_readback();
        t_rise_capture();
        t_disabled_polarity();
        t_w1c();
        t_both_edges();
        t_set_wins();
        t_readonly();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule